// File: doc/BRIEF.md
# Gain-Ranging Controller with Directional Hysteresis

This block chooses, for every converter sample, one step of a six-step gain ladder. The ladder is built from a three-position attenuator and a two-position amplifier. Its input is a peak-envelope level for the sample about to be converted, expressed as an unsigned number in 1 dB units. On each sample strobe the block compares that level against five switching thresholds. The thresholds are spaced by one 6 dB ladder step and start at a base level set by a parameter.

The block keeps the word chosen last time. A threshold that would move the gain towards less gain is applied at its nominal value. A threshold that would move the gain back towards more gain is applied 6 dB lower. A level sitting near one threshold therefore cannot make the word chatter.

When interleaved operation is enabled, samples carry a channel tag, and each channel keeps its own last word and so its own hysteresis direction. With interleaving off, all samples share the state of channel 0. The chosen word and its decoded attenuator and amplifier selects are registered one clock after the strobe, so they are ready before the measured sample is converted.

Top module: `gain_ranger`

## Requirements
- R1: After reset the output word is 101, the attenuator select is 10, the amplifier select is 1 and out_valid is 0. Every channel's stored word is 101.
- R2: The word encodes total gain as +18 dB minus 6 dB per count. Word bits [2:1] drive att_sel, where 00 means 0 dB, 01 means -12 dB and 10 means -24 dB. Word bit 0 drives amp_sel, where 0 means +18 dB and 1 means +12 dB.
- R3: Switching thresholds are T_j = BASE_DB + 6*j for j = 0..4 (defaults 20, 26, 32, 38, 44). Let U be the count of T_j that the level meets or exceeds. If U is above the stored word, the new word is U, even when that skips several steps.
- R4: Let D be the count of (T_j - 6) that the level meets or exceeds. If D is below the stored word, the new word is D.
- R5: When neither R3 nor R4 applies, the word stays unchanged. A rise and a fall are never both requested for one sample.
- R6: Words 110 and 111 never appear. Level 0 gives 000 and the largest level gives 101.
- R7: A strobe updates gain_word, att_sel, amp_sel and out_ch at the next clock edge, together with a one-cycle out_valid pulse. Without a strobe, the outputs hold whatever peak_lvl does.
- R8: With dual_en=1, ch_tag picks the state used and updated. The state of the other channel is untouched, and out_ch echoes the tag.
- R9: With dual_en=0, ch_tag is ignored. Channel 0 state is used and out_ch reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe; the level is valid this cycle |
| peak_lvl | input | LVL_W | Peak-envelope level in dB units |
| ch_tag | input | CH_W | Channel of this sample (used only in dual mode) |
| dual_en | input | 1 | Interleaved per-channel operation |
| gain_word | output | 3 | Registered ladder word |
| att_sel | output | 2 | Attenuator select (word[2:1]) |
| amp_sel | output | 1 | Amplifier select (word[0]) |
| out_ch | output | CH_W | Channel the current word belongs to |
| out_valid | output | 1 | One-cycle pulse after each strobe |

## Verification
The bench aims at the edges of the hysteresis band. A design that put the 6 dB offset on the wrong side, or left it out, would move the word on levels the band should absorb, or hold it where a step is due. It also drives falls of several steps at once, which expose a controller that only moves one step per sample. Two channels are parked at opposite ends of the ladder, so a design with shared state would pull one channel with the other. Finally, a tag is presented in single mode and the level is changed without a strobe, to catch designs that honour the tag or react outside a strobe.

// File: rtl/gain_ranger_pkg.sv
package gain_ranger_pkg;

  localparam int unsigned LADDER_STEPS = 6;
  localparam int unsigned N_THR        = LADDER_STEPS - 1;
  localparam int          STEP_DB      = 6;
  localparam int          TOP_GAIN_DB  = 18;

  typedef logic [2:0] gword_t;

  localparam gword_t WORD_MIN = 3'd0;
  localparam gword_t WORD_MAX = 3'(LADDER_STEPS - 1);

  // Count of threshold hits; the result is saturated onto the ladder.
  function automatic gword_t hits_to_word(input logic [N_THR-1:0] hits);
    int unsigned n;
    n = 0;
    for (int i = 0; i < N_THR; i++) n += int'(hits[i]);
    if (n > int'(WORD_MAX)) return WORD_MAX;
    return gword_t'(n);
  endfunction

  // Nominal switching threshold j in dB.
  function automatic int thr_db(input int base, input int j);
    return base + STEP_DB * j;
  endfunction

  // Total gain of a word in dB.
  function automatic int word_gain_db(input gword_t w);
    return TOP_GAIN_DB - STEP_DB * int'(w);
  endfunction

endpackage

// File: rtl/gain_ranger_decide.sv
module gain_ranger_decide
  import gain_ranger_pkg::*;
#(
  parameter int LVL_W   = 8,
  parameter int BASE_DB = 20,
  parameter int HYST_DB = 6
) (
  input  logic [LVL_W-1:0] level,
  input  gword_t           prev_word,
  output gword_t           next_word,
  output logic             go_up,
  output logic             go_down
);

  logic [N_THR-1:0] up_hit;
  logic [N_THR-1:0] dn_hit;
  gword_t           up_word;
  gword_t           dn_word;

  for (genvar j = 0; j < N_THR; j++) begin : g_thr
    localparam int T_RISE = thr_db(BASE_DB, j);
    localparam int T_FALL = T_RISE - HYST_DB;
    always_comb begin
      up_hit[j] = (int'({1'b0, level}) >= T_RISE);
      dn_hit[j] = (int'({1'b0, level}) >= T_FALL);
    end
  end

  always_comb begin
    up_word = hits_to_word(up_hit);
    dn_word = hits_to_word(dn_hit);
    go_up   = (up_word > prev_word);
    go_down = (dn_word < prev_word);
    if (go_up)        next_word = up_word;
    else if (go_down) next_word = dn_word;
    else              next_word = prev_word;
  end

endmodule

// File: rtl/gain_ranger_state.sv
module gain_ranger_state
  import gain_ranger_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] sel_ch,
  input  gword_t          wr_word,
  output gword_t          rd_word
);

  gword_t ch_word [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  ch_word[c] <= WORD_MAX;
      else if (wr_en && (int'(sel_ch) == c))       ch_word[c] <= wr_word;
    end
  end

  always_comb begin
    rd_word = WORD_MAX;
    for (int c = 0; c < NUM_CH; c++)
      if (int'(sel_ch) == c) rd_word = ch_word[c];
  end

endmodule

// File: rtl/gain_ranger_decode.sv
module gain_ranger_decode
  import gain_ranger_pkg::*;
(
  input  gword_t     word,
  output logic [1:0] att_sel,
  output logic       amp_sel
);

  always_comb begin
    att_sel = word[2:1];
    amp_sel = word[0];
  end

endmodule

// File: rtl/gain_ranger.sv
module gain_ranger
  import gain_ranger_pkg::*;
#(
  parameter  int LVL_W   = 8,
  parameter  int NUM_CH  = 2,
  parameter  int BASE_DB = 20,
  parameter  int HYST_DB = 6,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic [LVL_W-1:0] peak_lvl,
  input  logic [CH_W-1:0]  ch_tag,
  input  logic             dual_en,
  output logic [2:0]       gain_word,
  output logic [1:0]       att_sel,
  output logic             amp_sel,
  output logic [CH_W-1:0]  out_ch,
  output logic             out_valid
);

  logic [CH_W-1:0] eff_ch;
  gword_t          prev_word;
  gword_t          next_word;
  gword_t          word_q;
  logic            go_up;
  logic            go_down;

  assign eff_ch = dual_en ? ch_tag : '0;

  gain_ranger_state #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (smp_stb),
    .sel_ch  (eff_ch),
    .wr_word (next_word),
    .rd_word (prev_word)
  );

  gain_ranger_decide #(.LVL_W(LVL_W), .BASE_DB(BASE_DB), .HYST_DB(HYST_DB)) u_decide (
    .level     (peak_lvl),
    .prev_word (prev_word),
    .next_word (next_word),
    .go_up     (go_up),
    .go_down   (go_down)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= WORD_MAX;
      out_ch    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= smp_stb;
      if (smp_stb) begin
        word_q <= next_word;
        out_ch <= eff_ch;
      end
    end
  end

  gain_ranger_decode u_decode (
    .word    (word_q),
    .att_sel (att_sel),
    .amp_sel (amp_sel)
  );

  assign gain_word = word_q;

endmodule

// File: rtl/gain_ranger_chk.sv
module gain_ranger_chk #(
  parameter int CH_W = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_stb,
  input logic            dual_en,
  input logic [2:0]      gain_word,
  input logic [1:0]      att_sel,
  input logic [CH_W-1:0] out_ch,
  input logic            out_valid,
  input logic            go_up,
  input logic            go_down
);

  // R1
  reset_word_chk: assert property (@(posedge clk) !rst_n |=> (gain_word == 3'd5 && !out_valid));

  // R6
  legal_word_chk: assert property (@(posedge clk) disable iff (!rst_n) gain_word <= 3'd5);

  // R2
  legal_att_chk: assert property (@(posedge clk) disable iff (!rst_n) att_sel != 2'b11);

  // R5
  single_dir_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_stb |-> $onehot0({go_up, go_down}));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_stb |=> out_valid);

  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n) !smp_stb |=> ($stable(gain_word) && !out_valid));

  // R9
  single_ch_chk: assert property (@(posedge clk) disable iff (!rst_n) (smp_stb && !dual_en) |=> out_ch == '0);

endmodule

bind gain_ranger gain_ranger_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_stb   (smp_stb),
  .dual_en   (dual_en),
  .gain_word (gain_word),
  .att_sel   (att_sel),
  .out_ch    (out_ch),
  .out_valid (out_valid),
  .go_up     (go_up),
  .go_down   (go_down)
);

// File: tb/gain_ranger_bench.sv
module gain_ranger_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_stb = 1'b0;
  logic [7:0] peak_lvl = '0;
  logic [0:0] ch_tag = '0;
  logic       dual_en = 1'b0;
  logic [2:0] gain_word;
  logic [1:0] att_sel;
  logic       amp_sel;
  logic [0:0] out_ch;
  logic       out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int model [2];

  always #2 clk = ~clk;

  gain_ranger u_gain_ranger (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .peak_lvl(peak_lvl),
    .ch_tag(ch_tag), .dual_en(dual_en), .gain_word(gain_word),
    .att_sel(att_sel), .amp_sel(amp_sel), .out_ch(out_ch), .out_valid(out_valid)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Restated rule: rise to the nominal count, fall to the lowered count, else hold.
  function automatic int ref_word(input int lvl, input int prev);
    int up, dn;
    up = 0; dn = 0;
    for (int j = 0; j < 5; j++) begin
      if (lvl >= 20 + 6 * j) up++;
      if (lvl >= 14 + 6 * j) dn++;
    end
    if (up > prev) return up;
    if (dn < prev) return dn;
    return prev;
  endfunction

  task automatic sample(input int lvl, input int tag, input bit dual, input string req);
    int c, exp;
    c = dual ? tag : 0;
    exp = ref_word(lvl, model[c]);
    model[c] = exp;
    @(negedge clk);
    peak_lvl = 8'(lvl); ch_tag = 1'(tag); dual_en = dual; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    check(req, int'(gain_word), exp);
    check({req, "/R2 att"}, int'(att_sel), exp / 2);
    check({req, "/R2 amp"}, int'(amp_sel), exp % 2);
    check({req, "/R7 valid"}, int'(out_valid), 1);
    check({req, "/R8 ch"}, int'(out_ch), c);
  endtask

  task automatic t_reset;
    check("R1 word", int'(gain_word), 5);
    check("R1 att", int'(att_sel), 2);
    check("R1 amp", int'(amp_sel), 1);
    check("R1 valid", int'(out_valid), 0);
    sample(40, 1, 1'b1, "R1 ch1 starts at 101");
    check("R1 ch1 held", int'(gain_word), 5);
  endtask

  task automatic t_ladder;
    sample(0, 0, 1'b0, "R6 low clamp");
    check("R6 zero", int'(gain_word), 0);
    sample(20, 0, 1'b0, "R3 step1");
    sample(26, 0, 1'b0, "R3 step2");
    sample(32, 0, 1'b0, "R3 step3");
    sample(38, 0, 1'b0, "R3 step4");
    sample(44, 0, 1'b0, "R3 step5");
    sample(255, 0, 1'b0, "R6 high clamp");
    check("R6 top", int'(gain_word), 5);
    sample(0, 0, 1'b0, "R4 full fall");
    sample(40, 0, 1'b0, "R3 jump to 4");
    check("R3 multi-step rise", int'(gain_word), 4);
  endtask

  task automatic t_hyst;
    sample(44, 0, 1'b0, "R3 to 5");
    sample(40, 0, 1'b0, "R5 band at 5");
    check("R5 stays 5", int'(gain_word), 5);
    sample(38, 0, 1'b0, "R5 edge of band");
    check("R5 38 holds", int'(gain_word), 5);
    sample(37, 0, 1'b0, "R4 below band");
    check("R4 falls to 4", int'(gain_word), 4);
    sample(43, 0, 1'b0, "R5 band at 4");
    check("R5 stays 4", int'(gain_word), 4);
    sample(44, 0, 1'b0, "R3 rise at nominal");
    sample(31, 0, 1'b0, "R4 multi-step fall");
    check("R4 to 3", int'(gain_word), 3);
  endtask

  task automatic t_timing;
    int w;
    w = int'(gain_word);
    @(negedge clk);
    peak_lvl = 8'd0;
    @(negedge clk);
    check("R7 valid drops", int'(out_valid), 0);
    check("R7 no strobe hold", int'(gain_word), w);
    peak_lvl = 8'd255;
    @(negedge clk);
    check("R7 still held", int'(gain_word), w);
  endtask

  task automatic t_dual;
    sample(0, 0, 1'b1, "R8 ch0 low");
    sample(255, 1, 1'b1, "R8 ch1 high");
    sample(17, 0, 1'b1, "R8 ch0 own state");
    check("R8 ch0 stays 0", int'(gain_word), 0);
    sample(40, 1, 1'b1, "R8 ch1 own state");
    check("R8 ch1 stays 5", int'(gain_word), 5);
    check("R8 out_ch", int'(out_ch), 1);
  endtask

  task automatic t_single;
    sample(17, 1, 1'b0, "R9 tag ignored");
    check("R9 uses ch0", int'(gain_word), 0);
    check("R9 out_ch 0", int'(out_ch), 0);
    sample(40, 1, 1'b1, "R9 ch1 untouched");
    check("R9 ch1 still 5", int'(gain_word), 5);
  endtask

  initial begin
    model[0] = 5; model[1] = 5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ladder();
    t_hyst();
    t_timing();
    t_dual();
    t_single();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule